// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Open-Drain and Tachometer Taps

This block controls an eight-pin general-purpose I/O port. Software reaches it through a small synchronous register bus and sees three byte-wide registers: a direction register, an output-data register and a read-only input register. Toward the pad ring every pin gets three control signals: the data to drive, an output enable, and a weak-pullup enable. When a pin is an input, its output-data bit selects the weak pullup.

Pins 6 and 7 are open-drain. They never drive high and have no pullup. A master I2C function can take them over through a single enable input, and GPIO driving on both pins then stops. Every pin level passes through a two-flop synchronizer. The synchronized levels feed the input register and a falling-edge detector. The detector sends one-clock event pulses to external tachometer counters on pins 0 to 5. Each of those pins has its own enable, and the detector keeps working while the pin is driven as an output.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads 0x00 and the output-data register reads 0xFF. All output enables are 0, and the pullup enable is 1 on pins 0 to 5 and 0 on pins 6 and 7.
- R2: For pins 0 to 5, a direction bit of 1 asserts that pin's output enable, and the pad data equals the output-data bit. A direction bit of 0 deasserts the output enable.
- R3: For pins 0 to 5 set as input, the pullup enable equals the output-data bit. A pullup is never enabled on a pin whose output enable is asserted.
- R4: Pins 6 and 7 never assert the pullup enable and their pad data is always 0. Their output enable is 1 only when the direction bit is 1, the output-data bit is 0 and the I2C enable is 0.
- R5: While the I2C enable input is 1, the output enables of pins 6 and 7 are 0, whatever the direction and output-data bits hold.
- R6: A read at offset 2 returns the pin levels after a two-flop synchronizer. This holds for every direction and I2C setting.
- R7: A write at offset 2 or 3 changes neither the direction register nor the output-data register. A read at offset 3 returns 0x00.
- R8: Offset 0 selects the direction register and offset 1 selects the output-data register. Written values read back. Read data appears in the cycle after the address is presented.
- R9: A high-to-low level change on pin n (n = 0 to 5) gives exactly one one-clock pulse on tach_evt[n] when tach_en[n] is 1, including when the pin is a driven output. A rising change gives no pulse.
- R10: When tach_en[n] is 0, a falling level change on pin n gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset (0 direction, 1 output data, 2 input) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Data to drive on each pad |
| pad_oe | output | 8 | Output enable for each pad |
| pad_pu | output | 8 | Weak-pullup enable for each pad |
| i2c_en | input | 1 | Master I2C owns pins 6 and 7 |
| tach_en | input | 6 | Tachometer enable for pins 0 to 5 |
| tach_evt | output | 6 | One-clock falling-edge events for pins 0 to 5 |

## Verification
The bench builds the block with its default parameters: eight pins, pins 6 and 7 open-drain, and six tachometer taps. This setting lets every combination of open-drain pin, push-pull pin, I2C override and tap enable come up in the same random run. Because the taps cover only pins 0 to 5, the bench can also confirm that edges on pins 6 and 7 raise no event. Random direction, output-data, I2C and pin patterns are compared against a model of the pad rules. Directed sequences check the reset values, writes to the read-only offset, and the one-cycle edge pulses on both output and input pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_LVL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic drv;
        logic oe;
        logic pu;
    } pad_ctl_t;

    // push-pull pin: drive when output, pullup follows data when input
    function automatic pad_ctl_t pp_pad(input logic dir, input logic dat);
        pad_ctl_t p;
        p.drv = dat;
        p.oe  = dir;
        p.pu  = ~dir & dat;
        return p;
    endfunction

    // open-drain pin: only pulls low, no pullup, yields to alternate owner
    function automatic pad_ctl_t od_pad(input logic dir, input logic dat, input logic alt);
        pad_ctl_t p;
        p.drv = 1'b0;
        p.oe  = dir & ~dat & ~alt;
        p.pu  = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int              PINS    = 8,
    parameter logic [PINS-1:0] DIR_RST = '0,
    parameter logic [PINS-1:0] DAT_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   lvl,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   dat_q,
    output logic [PINS-1:0]   rdata
);

    reg_sel_e        sel;
    logic [PINS-1:0] rd_mux;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_RST;
            dat_q <= DAT_RST;
        end else if (we) begin
            if (sel == SEL_DIR)  dir_q <= wdata;
            if (sel == SEL_DATA) dat_q <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:  rd_mux = dir_q;
            SEL_DATA: rd_mux = dat_q;
            SEL_LVL:  rd_mux = lvl;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_port_sync_edge.sv
module gpio_port_sync_edge #(
    parameter int PINS      = 8,
    parameter int TACH_PINS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PINS-1:0]      pin_in,
    input  logic [TACH_PINS-1:0] tach_en,
    output logic [PINS-1:0]      lvl,
    output logic [TACH_PINS-1:0] evt
);

    logic [PINS-1:0]      meta_q;
    logic [TACH_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl    <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            lvl    <= meta_q;
            prev_q <= lvl[TACH_PINS-1:0];
        end
    end

    for (genvar i = 0; i < TACH_PINS; i++) begin : g_tap
        assign evt[i] = tach_en[i] & prev_q[i] & ~lvl[i];
    end

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
    import gpio_port_pkg::*;
#(
    parameter int              PINS    = 8,
    parameter logic [PINS-1:0] OD_MASK = 8'hC0
) (
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] dat,
    input  logic            alt_en,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pu
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pad_ctl_t ctl;
        if (OD_MASK[i]) begin : g_od
            assign ctl = od_pad(dir[i], dat[i], alt_en);
        end else begin : g_pp
            assign ctl = pp_pad(dir[i], dat[i]);
        end
        assign pad_out[i] = ctl.drv;
        assign pad_oe[i]  = ctl.oe;
        assign pad_pu[i]  = ctl.pu;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int              PINS      = 8,
    parameter int              TACH_PINS = 6,
    parameter logic [PINS-1:0] OD_MASK   = 8'hC0,
    parameter logic [PINS-1:0] DIR_RST   = '0,
    parameter logic [PINS-1:0] DAT_RST   = '1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [PINS-1:0]      bus_wdata,
    output logic [PINS-1:0]      bus_rdata,
    input  logic [PINS-1:0]      pin_in,
    output logic [PINS-1:0]      pad_out,
    output logic [PINS-1:0]      pad_oe,
    output logic [PINS-1:0]      pad_pu,
    input  logic                 i2c_en,
    input  logic [TACH_PINS-1:0] tach_en,
    output logic [TACH_PINS-1:0] tach_evt
);

    logic [PINS-1:0] lvl;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] dat_q;

    gpio_port_sync_edge #(.PINS(PINS), .TACH_PINS(TACH_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .tach_en(tach_en),
        .lvl    (lvl),
        .evt    (tach_evt)
    );

    gpio_port_regs #(.PINS(PINS), .DIR_RST(DIR_RST), .DAT_RST(DAT_RST)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .we   (bus_we),
        .wdata(bus_wdata),
        .lvl  (lvl),
        .dir_q(dir_q),
        .dat_q(dat_q),
        .rdata(bus_rdata)
    );

    gpio_port_pads #(.PINS(PINS), .OD_MASK(OD_MASK)) u_pads (
        .dir    (dir_q),
        .dat    (dat_q),
        .alt_en (i2c_en),
        .pad_out(pad_out),
        .pad_oe (pad_oe),
        .pad_pu (pad_pu)
    );

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter int              PINS      = 8,
    parameter int              TACH_PINS = 6,
    parameter logic [PINS-1:0] OD_MASK   = 8'hC0
) (
    input logic                 clk,
    input logic                 rst,
    input logic [1:0]           bus_addr,
    input logic                 bus_we,
    input logic [PINS-1:0]      bus_wdata,
    input logic [PINS-1:0]      pad_out,
    input logic [PINS-1:0]      pad_oe,
    input logic [PINS-1:0]      pad_pu,
    input logic                 i2c_en,
    input logic [TACH_PINS-1:0] tach_en,
    input logic [TACH_PINS-1:0] tach_evt
);

    // R2: a direction write shows up on push-pull output enables next cycle
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd0) |=>
            ((pad_oe & ~OD_MASK) == ($past(bus_wdata) & ~OD_MASK)));

    // R3: pullup and drive never together
    a_r3_pu_excl_oe: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    // R4: open-drain pins have no pullup and never drive high
    a_r4_od_low_only: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu & OD_MASK) == '0) && ((pad_out & OD_MASK) == '0));

    // R5: alternate owner releases open-drain pins
    a_r5_i2c_release: assert property (@(posedge clk) disable iff (rst)
        i2c_en |-> ((pad_oe & OD_MASK) == '0));

    // R9: an event never lasts two cycles
    a_r9_evt_single: assert property (@(posedge clk) disable iff (rst)
        (|tach_evt) |=> ((tach_evt & $past(tach_evt)) == '0));

    // R10: disabled taps stay quiet
    a_r10_evt_gated: assert property (@(posedge clk) disable iff (rst)
        (tach_evt & ~tach_en) == '0);

endmodule

bind gpio_port_ctrl gpio_port_checker #(
    .PINS(PINS), .TACH_PINS(TACH_PINS), .OD_MASK(OD_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .i2c_en   (i2c_en),
    .tach_en  (tach_en),
    .tach_evt (tach_evt)
);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OD = 8'hC0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic       i2c_en = 1'b0;
    logic [5:0] tach_en = '0;
    logic [5:0] tach_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_port_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .i2c_en(i2c_en), .tach_en(tach_en), .tach_evt(tach_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_oe(input logic [7:0] d, input logic [7:0] o, input logic a);
        return (d & ~OD) | (d & ~o & OD & {8{~a}});
    endfunction
    function automatic logic [7:0] m_pu(input logic [7:0] d, input logic [7:0] o);
        return ~d & o & ~OD;
    endfunction
    function automatic logic [7:0] m_out(input logic [7:0] o);
        return o & ~OD;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1 v = bus_rdata;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic count_evt(input int n, output int c0, output int cother);
        c0 = 0; cother = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            c0 += tach_evt[0];
            cother += $countones(tach_evt[5:1]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d, o, p;
        int c0, co;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h3F);
        rd(2'd0, v); check("R1 dir", v, 8'h00);
        rd(2'd1, v); check("R1 dat", v, 8'hFF);

        // R8 readback and latency
        wr(2'd0, 8'h5A);
        rd(2'd0, v); check("R8 dir rb", v, 8'h5A);
        wr(2'd1, 8'h3C);
        rd(2'd1, v); check("R8 dat rb", v, 8'h3C);

        // R7 writes to offsets 2 and 3 ignored
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h0F);
        rd(2'd0, v); check("R7 dir kept", v, 8'h5A);
        rd(2'd1, v); check("R7 dat kept", v, 8'h3C);
        rd(2'd3, v); check("R7 off3 zero", v, 8'h00);

        // R4 R5 directed on open-drain pins
        wr(2'd0, 8'hC0); wr(2'd1, 8'h40);
        #1 check("R4 od low drive", pad_oe & OD, 8'h80);
        check("R4 od out", pad_out & OD, 8'h00);
        @(negedge clk) i2c_en = 1'b1; #1;
        check("R5 i2c release", pad_oe & OD, 8'h00);
        @(negedge clk) i2c_en = 1'b0;

        // R2 R3 R4 R5 R6 random
        for (int it = 0; it < 60; it++) begin
            d = 8'($urandom); o = 8'($urandom); p = 8'($urandom);
            wr(2'd0, d); wr(2'd1, o);
            @(negedge clk); i2c_en = 1'($urandom); pin_in = p;
            settle(3);
            #1;
            check("R2 oe", pad_oe & ~OD, m_oe(d, o, i2c_en) & ~OD);
            check("R4 R5 od oe", pad_oe & OD, m_oe(d, o, i2c_en) & OD);
            check("R2 out", pad_out, m_out(o));
            check("R3 pu", pad_pu, m_pu(d, o));
            rd(2'd2, v); check("R6 lvl", v, p);
        end
        @(negedge clk) i2c_en = 1'b0;

        // R6 latency: two synchronizer flops then registered read
        @(negedge clk) bus_addr = 2'd2; pin_in = 8'h00;
        settle(3);
        @(negedge clk) pin_in = 8'hA5;
        @(posedge clk); @(posedge clk); #1;
        check("R6 not yet", bus_rdata, 8'h00);
        @(posedge clk); #1;
        check("R6 arrived", bus_rdata, 8'hA5);

        // R9 falling edge on a driven output pin, one pulse, exact cycle
        wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        @(negedge clk) tach_en = 6'h3F; pin_in = 8'hFF;
        settle(4);
        @(negedge clk) pin_in = 8'hFE;
        @(posedge clk); #1; check("R9 no early evt", tach_evt, 6'h00);
        @(posedge clk); #1; check("R9 pulse", tach_evt, 6'h01);
        @(posedge clk); #1; check("R9 one cycle", tach_evt, 6'h00);

        // R9 rising edge gives nothing
        @(negedge clk) pin_in = 8'hFF;
        count_evt(6, c0, co);
        check("R9 rising none", c0 + co, 0);

        // R9 falling on input pin, other pins untouched
        wr(2'd0, 8'h00);
        @(negedge clk) pin_in = 8'hFE;
        count_evt(6, c0, co);
        check("R9 input pin pulse", c0, 1);
        check("R9 others quiet", co, 0);

        // R9 pins 6,7 have no taps
        @(negedge clk) pin_in = 8'h3F;
        count_evt(6, c0, co);
        check("R9 od pins no evt", c0 + co, 0);

        // R10 disabled tap
        @(negedge clk) pin_in = 8'hFF; tach_en = 6'h3E;
        settle(4);
        @(negedge clk) pin_in = 8'hFE;
        count_evt(6, c0, co);
        check("R10 gated", c0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule